// File: doc/BRIEF.md
# Serial-Load DAC Code Register Front End

This block is the digital side of a 12-bit serial-load converter. It samples five external control pins on a fast system clock: an active-low select, a serial clock, serial data, an active-low load strobe and an active-low clear. Serial bits go into an input shift register. The converter core sees a separate output register through a parallel code bus. Because the two registers are separate, a new code can be preloaded without moving the analog output.

The load strobe acts on its level. While it is low, the output register tracks the shift register. When it returns high, the value is held. Clear takes priority over load and zeroes the output register. It stays zero until the next load. A sticky flag reports the forbidden case of shifting data while the load strobe is low.

Every pin passes through a two-flop synchronizer before any edge detection or decoding. The ladder, the reference and the amplifier are outside this block.

Top module: `serial_dac_front`

## Requirements
- R1: After reset, code_o is 0 (zero scale) and viol_o is 0.
- R2: Each rising edge of sclk_i seen while cs_ni is low shifts sdin_i into bit 0 of the shift register. Bit 11 is the first bit sent (most significant first), so the 12th bit sent lands in bit 0.
- R3: While cs_ni is high, sclk_i edges leave the shift register unchanged.
- R4: If more than 12 qualified edges occur, only the last 12 bits received are kept. Older bits fall out of the top.
- R5: While ld_ni is high and clr_ni is high, code_o holds its value, even while new bits are shifted in.
- R6: While ld_ni is low and clr_ni is high, code_o follows the shift register. A rising edge on ld_ni freezes the current value.
- R7: clr_ni low forces code_o to 0 without any serial clock activity. code_o stays 0 after clr_ni returns high, until the next load.
- R8: clr_ni has priority: while clr_ni and ld_ni are both low, code_o is 0.
- R9: A qualified sclk_i rising edge while ld_ni is low sets viol_o. viol_o stays set until rst_ni is asserted.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System sampling clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cs_ni | input | 1 | Active-low select pin |
| sclk_i | input | 1 | Serial clock pin |
| sdin_i | input | 1 | Serial data pin, most significant bit first |
| ld_ni | input | 1 | Active-low level-sensitive load strobe |
| clr_ni | input | 1 | Active-low clear of the output register |
| code_o | output | 12 | Parallel code to the converter core |
| viol_o | output | 1 | Sticky flag: data shifted while load was low |

## Verification
The assertions check the following on every cycle, using the synchronized pin levels:
- a qualified edge shifts exactly one bit in;
- the shift register holds while deselected;
- the output is zero after clear, with clear taking priority over load;
- the output follows the shift register during load and holds otherwise;
- the violation flag never drops once set.

Only the bench's scenarios show the end-to-end results at the pins. These are the final code after frames of 12, 14 and 16 bits, the most-significant-first order, and the zero persisting after clear is released. They also include preloading behind a held output and the flag clearing on reset.

// File: rtl/serial_dac_front_pkg.sv
package serial_dac_front_pkg;
  localparam int unsigned CODE_W      = 12;
  localparam int unsigned SYNC_STAGES = 2;
  typedef logic [CODE_W-1:0] code_t;
endpackage

// File: rtl/serial_dac_front_sync.sv
module serial_dac_front_sync #(
  parameter int unsigned      W      = 1,
  parameter int unsigned      STAGES = 2,
  parameter logic [W-1:0]     RST_V  = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [STAGES-1:0][W-1:0] stg_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < STAGES; i++) stg_q[i] <= RST_V;
    end else begin
      stg_q[0] <= d_i;
      for (int i = 1; i < STAGES; i++) stg_q[i] <= stg_q[i-1];
    end
  end

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/serial_dac_front_shift.sv
module serial_dac_front_shift #(
  parameter int unsigned CODE_W = 12
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cs_n_s_i,
  input  logic              sclk_s_i,
  input  logic              sdin_s_i,
  output logic              step_o,
  output logic [CODE_W-1:0] shift_o
);
  logic              sclk_d_q;
  logic [CODE_W-1:0] shift_q;

  // qualified rising edge of the synchronized serial clock
  assign step_o = sclk_s_i & ~sclk_d_q & ~cs_n_s_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sclk_d_q <= 1'b0;
      shift_q  <= '0;
    end else begin
      sclk_d_q <= sclk_s_i;
      if (step_o) shift_q <= {shift_q[CODE_W-2:0], sdin_s_i};
    end
  end

  assign shift_o = shift_q;
endmodule

// File: rtl/serial_dac_front_outreg.sv
module serial_dac_front_outreg #(
  parameter int unsigned CODE_W = 12
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clr_n_s_i,
  input  logic              ld_n_s_i,
  input  logic [CODE_W-1:0] shift_i,
  output logic [CODE_W-1:0] code_o
);
  logic [CODE_W-1:0] code_q;

  // clear wins over load; load level makes the register follow the shifter
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         code_q <= '0;
    else if (!clr_n_s_i) code_q <= '0;
    else if (!ld_n_s_i)  code_q <= shift_i;
  end

  assign code_o = code_q;
endmodule

// File: rtl/serial_dac_front.sv
module serial_dac_front
  import serial_dac_front_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cs_ni,
  input  logic              sclk_i,
  input  logic              sdin_i,
  input  logic              ld_ni,
  input  logic              clr_ni,
  output logic [CODE_W-1:0] code_o,
  output logic              viol_o
);
  localparam int unsigned PIN_N = 5;
  // pin order in the sync vector: {clr_n, ld_n, sdin, sclk, cs_n}
  localparam logic [PIN_N-1:0] PIN_RST = 5'b11001;

  logic [PIN_N-1:0] pins_s;
  logic  cs_n_s, sclk_s, sdin_s, ld_n_s, clr_n_s;
  logic  step;
  code_t shift_q;
  logic  viol_q;

  serial_dac_front_sync #(
    .W(PIN_N), .STAGES(SYNC_STAGES), .RST_V(PIN_RST)
  ) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    ({clr_ni, ld_ni, sdin_i, sclk_i, cs_ni}),
    .q_o    (pins_s)
  );

  assign {clr_n_s, ld_n_s, sdin_s, sclk_s, cs_n_s} = pins_s;

  serial_dac_front_shift #(.CODE_W(CODE_W)) u_shift (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .cs_n_s_i (cs_n_s),
    .sclk_s_i (sclk_s),
    .sdin_s_i (sdin_s),
    .step_o   (step),
    .shift_o  (shift_q)
  );

  serial_dac_front_outreg #(.CODE_W(CODE_W)) u_out (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .clr_n_s_i (clr_n_s),
    .ld_n_s_i  (ld_n_s),
    .shift_i   (shift_q),
    .code_o    (code_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)               viol_q <= 1'b0;
    else if (step && !ld_n_s)  viol_q <= 1'b1;
  end

  assign viol_o = viol_q;
endmodule

// File: rtl/serial_dac_front_chk.sv
module serial_dac_front_chk #(
  parameter int unsigned CODE_W = 12
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              cs_n_s,
  input logic              ld_n_s,
  input logic              clr_n_s,
  input logic              sdin_s,
  input logic              step,
  input logic [CODE_W-1:0] shift_q,
  input logic [CODE_W-1:0] code_o,
  input logic              viol_o
);
  // R2
  shift_in_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    step |=> shift_q == {$past(shift_q[CODE_W-2:0]), $past(sdin_s)});

  // R3
  desel_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cs_n_s |=> $stable(shift_q));

  // R5
  out_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ld_n_s && clr_n_s) |=> $stable(code_o));

  // R6
  out_follow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ld_n_s && clr_n_s) |=> code_o == $past(shift_q));

  // R7, R8
  clr_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !clr_n_s |=> code_o == '0);

  // R9
  viol_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    viol_o |=> viol_o);

  // R9
  viol_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step && !ld_n_s) |=> viol_o);
endmodule

bind serial_dac_front serial_dac_front_chk #(.CODE_W(serial_dac_front_pkg::CODE_W)) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .cs_n_s  (cs_n_s),
  .ld_n_s  (ld_n_s),
  .clr_n_s (clr_n_s),
  .sdin_s  (sdin_s),
  .step    (step),
  .shift_q (shift_q),
  .code_o  (code_o),
  .viol_o  (viol_o)
);

// File: tb/serial_dac_front_test.sv
module serial_dac_front_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cs_n = 1'b1, sclk = 1'b0, sdin = 1'b0, ld_n = 1'b1, clr_n = 1'b1;
  logic [11:0] code;
  logic        viol;
  int          n_chk = 0, n_fail = 0;
  bit          done = 1'b0;

  always #2 clk = ~clk;

  serial_dac_front uut (
    .clk_i(clk), .rst_ni(rst_n), .cs_ni(cs_n), .sclk_i(sclk), .sdin_i(sdin),
    .ld_ni(ld_n), .clr_ni(clr_n), .code_o(code), .viol_o(viol)
  );

  // {bit count, frame data, expected code after load}
  localparam int NV = 6;
  localparam logic [4:0]  V_N [NV] = '{5'd12, 5'd12, 5'd12, 5'd14, 5'd16, 5'd12};
  localparam logic [15:0] V_D [NV] = '{16'h0A5C, 16'h0FFF, 16'h0000, 16'h3123, 16'hBEEF, 16'h0800};
  localparam logic [11:0] V_E [NV] = '{12'hA5C, 12'hFFF, 12'h000, 12'h123, 12'hEEF, 12'h800};

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string tag, input logic [11:0] act, input logic [11:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic send(input logic [15:0] d, input int n, input bit sel);
    cs_n = ~sel; wait_clk(4);
    for (int i = n - 1; i >= 0; i--) begin
      sdin = d[i]; sclk = 1'b0; wait_clk(4);
      sclk = 1'b1; wait_clk(4);
    end
    sclk = 1'b0; wait_clk(4);
    cs_n = 1'b1; wait_clk(4);
  endtask

  task automatic pulse_ld;
    ld_n = 1'b0; wait_clk(6);
    ld_n = 1'b1; wait_clk(6);
  endtask

  initial begin
    wait_clk(3);
    // R1: reset state
    check("R1 code", code, 12'h000);
    check("R1 viol", {11'd0, viol}, 12'd0);
    rst_n = 1'b1; wait_clk(4);
    check("R1 code after release", code, 12'h000);

    // R2 R4 R6: frames of several lengths
    for (int v = 0; v < NV; v++) begin
      send(V_D[v], int'(V_N[v]), 1'b1);
      pulse_ld();
      check($sformatf("R2/R4/R6 vec%0d", v), code, V_E[v]);
    end

    // R5: preload behind held output
    send(16'h0321, 12, 1'b1);
    check("R5 hold during preload", code, 12'h800);
    wait_clk(10);
    check("R5 still held", code, 12'h800);

    // R6: transparent while low, then latched
    ld_n = 1'b0; wait_clk(6);
    check("R6 transparent", code, 12'h321);
    ld_n = 1'b1; wait_clk(6);
    check("R6 latched", code, 12'h321);

    // R7: clear then persists
    clr_n = 1'b0; wait_clk(6);
    check("R7 clear", code, 12'h000);
    clr_n = 1'b1; wait_clk(10);
    check("R7 stays zero", code, 12'h000);

    // R3: deselected clocks ignored
    send(16'h0F0F, 12, 1'b0);
    pulse_ld();
    check("R3 deselected ignored", code, 12'h321);

    // R8: clear wins over load
    clr_n = 1'b0; ld_n = 1'b0; wait_clk(8);
    check("R8 clr priority", code, 12'h000);
    clr_n = 1'b1; wait_clk(8);
    check("R8 follows after clr", code, 12'h321);
    ld_n = 1'b1; wait_clk(6);
    check("R9 no viol yet", {11'd0, viol}, 12'd0);

    // R9: shifting while load low
    ld_n = 1'b0; wait_clk(4);
    send(16'h0001, 1, 1'b1);
    check("R9 viol set", {11'd0, viol}, 12'd1);
    ld_n = 1'b1; wait_clk(20);
    check("R9 viol sticky", {11'd0, viol}, 12'd1);
    rst_n = 1'b0; wait_clk(2);
    check("R1 R9 viol cleared by reset", {11'd0, viol}, 12'd0);
    check("R1 code zero on reset", code, 12'h000);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    wait_clk(50000);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule